// File: doc/BRIEF.md
# Single-Wire Monitor Serial Link

This block is a half-duplex serial transceiver that talks to a host over one shared data line. The line idles high through an external pull-up, and either end pulls it low. Bytes travel in NRZ frames at one rate in both directions. The block splits the line into an input sample (`line_i`) and a drive pair (`line_oe_o`, `line_out_o`), so the pad around it decides how the drive reaches the wire.

Every correctly framed byte from the host is reported on a one-clock receive strobe and sent back on the line. A frame whose bits are all low, stop bit included, is a break. The block answers a break with two bit periods of driven high and then a break of its own. A frame that has a low stop bit but some data bits high is counted as a framing error and dropped. Local bytes enter through a valid/ready handshake and go out only when the line is free.

The bit rate is fixed while reset is asserted. It comes either from a speed strap, which gives the base rate or twice the base rate, or from an integer multiplier value of 1 to 6.

Top module: `mon_link`

## Requirements
- R1: While `line_oe_o` is 1 the block drives the line with `line_out_o`. A transmitted frame is one low start bit, then eight data bits with bit 0 first, then one high stop bit, and every bit lasts exactly one bit period. The line is released (`line_oe_o` = 0) after each frame and while reset is asserted.
- R2: The bit period is 16 × max(1, floor((BASE_BIT_CLKS/16)/M)) clocks. When `use_mult_i` is low, M = 1 if `speed_strap_i` is high and M = 2 if it is low. The strap, `use_mult_i` and `mult_n_i` are sampled only while `rst_n` is low, and changing them afterwards has no effect.
- R3: When `use_mult_i` is high at reset, M = `mult_n_i` for values 1 to 6. A value of 0 counts as 1, and a value above 6 counts as 6.
- R4: A host frame with a high stop bit produces a one-clock `rx_valid_o` pulse, with the byte on `rx_data_o` in the same cycle.
- R5: Each correctly received byte is sent back exactly once as an R1 frame. It goes out only after the line has been idle for one bit period.
- R6: A start bit followed by nine low bit periods (all data bits low and the stop bit low) produces one `break_o` pulse and no `rx_valid_o`.
- R7: After a break, once the line has been high for one bit period, the block drives the line high for exactly 2 bit periods, then low for exactly 10 bit periods, and then releases it.
- R8: A frame with a low stop bit and at least one data bit high produces one `frame_err_o` pulse, no `rx_valid_o` and no echo. At most one of `rx_valid_o`, `break_o` and `frame_err_o` is high in any cycle.
- R9: A start bit that is high again at its midpoint is discarded. It produces no pulse and no drive.
- R10: The block never drives the line while it is receiving a frame, and `tx_ready_o` stays low during a host frame. While the block is transmitting, its receiver ignores the line, so its own frames never produce a receive pulse.
- R11: `tx_ready_o` is high for one clock on sub-bit ticks, and only when all of these hold: the transmitter is idle, no echo or break response is pending, and the line has been idle for one bit period. A byte taken when `tx_valid_i` and `tx_ready_o` are both high starts on the line in the next cycle and is sent exactly once as an R1 frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the rate inputs are sampled while it is low |
| speed_strap_i | input | 1 | Rate strap: 1 gives the base rate, 0 gives twice the base rate |
| use_mult_i | input | 1 | 1 selects the multiplier path for the rate |
| mult_n_i | input | 3 | Rate multiplier N |
| line_i | input | 1 | Sampled level of the shared data line |
| line_oe_o | output | 1 | 1 while the block drives the line |
| line_out_o | output | 1 | Level driven onto the line when `line_oe_o` is 1 |
| tx_valid_i | input | 1 | A local byte is offered for sending |
| tx_data_i | input | 8 | Local byte to send |
| tx_ready_o | output | 1 | The offered byte is accepted in this cycle |
| rx_valid_o | output | 1 | One-clock strobe for a received byte |
| rx_data_o | output | 8 | Received byte |
| break_o | output | 1 | One-clock strobe when a break is recognised |
| frame_err_o | output | 1 | One-clock strobe when a frame has a bad stop bit |

## Verification
Some properties are checked on every cycle by the assertions:
- the sub-bit tick comes exactly once per latched divisor;
- the driven level changes only on tick boundaries;
- the three receive outcomes never coincide;
- the line is never driven while a frame is being received, and the receiver is idle whenever the transmitter is busy;
- an accepted local byte puts the line under drive in the next cycle.

Other behaviour only the bench scenarios can show:
- exact bit periods for each strap and multiplier setting;
- the echoed byte values;
- the two-bit high interval and the ten-bit low of the break answer;
- that framing errors and start glitches are dropped silently;
- that a strap change after reset leaves the rate unchanged.

// File: rtl/mon_link_pkg.sv
// Package: shared types and the rate-selection rule for the monitor serial link.
// Assumes: the multiplier path clamps its value to 1..max_mult.
package mon_link_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAITHI
    } rx_state_e;

    // Rate multiplier M picked from the reset-time inputs.
    function automatic int unsigned rate_mult(input logic strap,
                                              input logic use_mult,
                                              input int unsigned n,
                                              input int unsigned max_mult);
        int unsigned m;
        if (use_mult) begin
            if (n == 0)             m = 1;
            else if (n > max_mult)  m = max_mult;
            else                    m = n;
        end else begin
            m = strap ? 1 : 2;
        end
        return m;
    endfunction

endpackage

// File: rtl/mon_baud.sv
// Sub-bit tick generator.
// The divisor is latched while reset is held and then fixed until the next reset.
// One tick is a one-clock pulse once every DIV clocks, and 16 ticks make one bit period.
// Assumes: BASE_TICK >= 1.
module mon_baud #(
    parameter int BASE_TICK = 64,
    parameter int MAX_MULT  = 6,
    parameter int NW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_i,
    input  logic          use_mult_i,
    input  logic [NW-1:0] mult_i,
    output logic          tick_o
);
    import mon_link_pkg::*;

    localparam int TDW = $clog2(BASE_TICK + 1);

    logic [TDW-1:0] div_next;
    logic [TDW-1:0] div_q;
    logic [TDW-1:0] cnt_q;
    logic           tick_q;

    // Divisor from the rate inputs, never below one clock.
    always_comb begin
        int unsigned m;
        int unsigned d;
        m = rate_mult(strap_i, use_mult_i, int'(mult_i), MAX_MULT);
        d = BASE_TICK / m;
        if (d == 0) d = 1;
        div_next = TDW'(d);
    end

    // Latch the divisor during reset; afterwards count clocks and pulse the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= div_next;
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == div_q - TDW'(1)) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + TDW'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // Independent gap counter: clocks since the last tick.
    logic [TDW:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      gap_q <= '0;
        else if (tick_q) gap_q <= (TDW+1)'(1);
        else             gap_q <= gap_q + (TDW+1)'(1);
    end

    // R2: each tick arrives exactly one latched divisor after the previous one.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> (gap_q == {1'b0, div_q}));

endmodule

// File: rtl/mon_rx.sv
// Receiver: mid-bit sampling at 16 ticks per bit, with start-glitch rejection.
// Each frame is classified as a good byte, a break or a framing error.
// Assumes: en_i is low while the local transmitter drives the line.
// A new start is armed only after the line has been seen high.
module mon_rx #(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 en_i,
    input  logic                 line_i,
    output logic                 line_s_o,
    output logic                 busy_o,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 brk_o,
    output logic                 ferr_o
);
    import mon_link_pkg::*;

    localparam int SW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(DATA_BITS);
    localparam logic [SW-1:0] SUB_LAST = SW'(OVERSAMPLE - 1);
    localparam logic [SW-1:0] SUB_MID  = SW'(OVERSAMPLE / 2 - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

    logic                 s1_q, s2_q;
    logic                 armed_q;
    rx_state_e            state_q;
    logic [SW-1:0]        sub_q;
    logic [BW-1:0]        bitn_q;
    logic [DATA_BITS-1:0] shreg_q;

    // Two-flop synchroniser for the line input; the idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
        end
    end

    // Frame state machine: start check, data shifting, stop classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            armed_q <= 1'b0;
            sub_q   <= '0;
            bitn_q  <= '0;
            shreg_q <= '0;
            valid_o <= 1'b0;
            data_o  <= '0;
            brk_o   <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            brk_o   <= 1'b0;
            ferr_o  <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (!en_i)     armed_q <= 1'b0;
                    else if (s2_q) armed_q <= 1'b1;
                    if (tick_i && en_i && armed_q && !s2_q) begin
                        state_q <= RX_START;
                        sub_q   <= '0;
                    end
                end
                RX_START: if (tick_i) begin
                    if (sub_q == SUB_MID) begin
                        sub_q  <= '0;
                        bitn_q <= '0;
                        state_q <= s2_q ? RX_IDLE : RX_DATA;
                    end else begin
                        sub_q <= sub_q + SW'(1);
                    end
                end
                RX_DATA: if (tick_i) begin
                    if (sub_q == SUB_LAST) begin
                        sub_q   <= '0;
                        shreg_q <= {s2_q, shreg_q[DATA_BITS-1:1]};
                        if (bitn_q == BIT_LAST) state_q <= RX_STOP;
                        else                    bitn_q  <= bitn_q + BW'(1);
                    end else begin
                        sub_q <= sub_q + SW'(1);
                    end
                end
                RX_STOP: if (tick_i) begin
                    if (sub_q == SUB_LAST) begin
                        sub_q <= '0;
                        if (s2_q) begin
                            valid_o <= 1'b1;
                            data_o  <= shreg_q;
                            state_q <= RX_IDLE;
                        end else begin
                            if (shreg_q == '0) brk_o  <= 1'b1;
                            else               ferr_o <= 1'b1;
                            state_q <= RX_WAITHI;
                        end
                    end else begin
                        sub_q <= sub_q + SW'(1);
                    end
                end
                RX_WAITHI: if (s2_q) state_q <= RX_IDLE;
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign line_s_o = s2_q;
    assign busy_o   = (state_q != RX_IDLE);

    // R8: a frame ends in exactly one outcome, never two at once.
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({valid_o, brk_o, ferr_o}) <= 1);

endmodule

// File: rtl/mon_tx.sv
// Transmitter: sends a byte frame or the break answer, one bit per 16 ticks.
// Byte frame: start low, data LSB first, stop high.
// Break answer: two high bits, then DATA_BITS+2 low bits.
// Assumes: go_i is asserted only on a tick while busy_o is low, so every bit is exact.
module mon_tx #(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 go_i,
    input  logic                 brk_i,
    input  logic [DATA_BITS-1:0] data_i,
    output logic                 busy_o,
    output logic                 line_oe_o,
    output logic                 line_out_o
);
    localparam int SW        = $clog2(OVERSAMPLE);
    localparam int FRAME_LEN = DATA_BITS + 2;
    localparam int RESP_LEN  = DATA_BITS + 4;
    localparam int CW        = $clog2(RESP_LEN + 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(OVERSAMPLE - 1);

    logic [RESP_LEN-1:0] load_vec;
    logic [RESP_LEN-1:0] shreg_q;
    logic [CW-1:0]       left_q;
    logic [SW-1:0]       sub_q;
    logic                kind_q;

    // Pattern to load: the break answer or a byte frame padded with ones.
    always_comb begin
        if (brk_i) load_vec = {{(DATA_BITS + 2){1'b0}}, 2'b11};
        else       load_vec = {3'b111, data_i, 1'b0};
    end

    // Shift one bit out every OVERSAMPLE ticks and release the line after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q    <= '1;
            left_q     <= '0;
            sub_q      <= '0;
            kind_q     <= 1'b0;
            busy_o     <= 1'b0;
            line_oe_o  <= 1'b0;
            line_out_o <= 1'b1;
        end else if (!busy_o) begin
            if (go_i) begin
                shreg_q    <= load_vec;
                left_q     <= brk_i ? CW'(RESP_LEN) : CW'(FRAME_LEN);
                sub_q      <= '0;
                kind_q     <= brk_i;
                busy_o     <= 1'b1;
                line_oe_o  <= 1'b1;
                line_out_o <= load_vec[0];
            end
        end else if (tick_i) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                if (left_q == CW'(1)) begin
                    busy_o     <= 1'b0;
                    line_oe_o  <= 1'b0;
                    line_out_o <= 1'b1;
                end else begin
                    shreg_q    <= {1'b1, shreg_q[RESP_LEN-1:1]};
                    line_out_o <= shreg_q[1];
                    left_q     <= left_q - CW'(1);
                end
            end else begin
                sub_q <= sub_q + SW'(1);
            end
        end
    end

    // R1: while driving, the level changes only on a tick boundary.
    p_bit_edges_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe_o && $past(line_oe_o) && (line_out_o != $past(line_out_o)))
            |-> $past(tick_i));

    // R7: a break answer starts high; a byte frame starts low.
    p_first_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe_o) |-> (line_out_o == kind_q));

endmodule

// File: rtl/mon_link.sv
// Top of the single-wire monitor serial link.
// Joins the tick generator, receiver and transmitter, and queues one byte echo and one break answer.
// Transmit starts on a tick only, after the line has been idle for one bit period.
// Priority: break answer, then byte echo, then a local byte.
// Assumes: the line has an external pull-up, and the host never drives while this block drives.
module mon_link #(
    parameter int BASE_BIT_CLKS = 1024,
    parameter int OVERSAMPLE    = 16,
    parameter int DATA_BITS     = 8,
    parameter int MAX_MULT      = 6,
    parameter int NW            = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 speed_strap_i,
    input  logic                 use_mult_i,
    input  logic [NW-1:0]        mult_n_i,
    input  logic                 line_i,
    output logic                 line_oe_o,
    output logic                 line_out_o,
    input  logic                 tx_valid_i,
    input  logic [DATA_BITS-1:0] tx_data_i,
    output logic                 tx_ready_o,
    output logic                 rx_valid_o,
    output logic [DATA_BITS-1:0] rx_data_o,
    output logic                 break_o,
    output logic                 frame_err_o
);
    localparam int BASE_TICK = BASE_BIT_CLKS / OVERSAMPLE;
    localparam int IW        = $clog2(OVERSAMPLE + 1);

    logic                 tick;
    logic                 line_s;
    logic                 rx_busy;
    logic                 tx_busy;
    logic                 rxv;
    logic [DATA_BITS-1:0] rxd;
    logic                 rxb;
    logic                 rxf;
    logic [IW-1:0]        idle_q;
    logic                 line_idle;
    logic                 can_launch;
    logic                 go;
    logic [DATA_BITS-1:0] go_data;
    logic                 echo_pend_q;
    logic [DATA_BITS-1:0] echo_byte_q;
    logic                 brk_pend_q;

    mon_baud #(
        .BASE_TICK (BASE_TICK),
        .MAX_MULT  (MAX_MULT),
        .NW        (NW)
    ) u_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (speed_strap_i),
        .use_mult_i (use_mult_i),
        .mult_i     (mult_n_i),
        .tick_o     (tick)
    );

    mon_rx #(
        .OVERSAMPLE (OVERSAMPLE),
        .DATA_BITS  (DATA_BITS)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .en_i     (!tx_busy),
        .line_i   (line_i),
        .line_s_o (line_s),
        .busy_o   (rx_busy),
        .valid_o  (rxv),
        .data_o   (rxd),
        .brk_o    (rxb),
        .ferr_o   (rxf)
    );

    // Idle timer: counts ticks of a quiet, high line up to one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)                              idle_q <= '0;
        else if (!line_s || rx_busy || tx_busy)  idle_q <= '0;
        else if (tick && idle_q != IW'(OVERSAMPLE)) idle_q <= idle_q + IW'(1);
    end

    assign line_idle  = (idle_q == IW'(OVERSAMPLE));
    assign can_launch = tick && line_idle && !tx_busy;
    assign go         = can_launch && (brk_pend_q || echo_pend_q || tx_valid_i);
    assign go_data    = echo_pend_q ? echo_byte_q : tx_data_i;
    assign tx_ready_o = can_launch && !brk_pend_q && !echo_pend_q;

    // Pending answers: set by receive outcomes, cleared when sent (break first).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_pend_q <= 1'b0;
            echo_byte_q <= '0;
            brk_pend_q  <= 1'b0;
        end else begin
            if (rxv) begin
                echo_pend_q <= 1'b1;
                echo_byte_q <= rxd;
            end else if (go && !brk_pend_q && echo_pend_q) begin
                echo_pend_q <= 1'b0;
            end
            if (rxb)                    brk_pend_q <= 1'b1;
            else if (go && brk_pend_q)  brk_pend_q <= 1'b0;
        end
    end

    mon_tx #(
        .OVERSAMPLE (OVERSAMPLE),
        .DATA_BITS  (DATA_BITS)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .go_i       (go),
        .brk_i      (brk_pend_q),
        .data_i     (go_data),
        .busy_o     (tx_busy),
        .line_oe_o  (line_oe_o),
        .line_out_o (line_out_o)
    );

    assign rx_valid_o  = rxv;
    assign rx_data_o   = rxd;
    assign break_o     = rxb;
    assign frame_err_o = rxf;

    // R10: no drive while a frame is being received.
    p_quiet_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |-> !line_oe_o);

    // R10: the receiver stays idle while the transmitter owns the line.
    p_rx_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !rx_busy);

    // R11: an accepted local byte puts the line under drive in the next cycle.
    p_accept_drives_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o) |=> line_oe_o);

endmodule

// File: tb/tb_mon_link.sv
// Bench for mon_link. A vector table covers the rate settings; directed tests cover reset,
// break, framing error, glitch, handshake and hold-off.
module tb_mon_link;

    localparam int BB = 192;
    localparam int TK = BB / 16;

    typedef struct packed {
        logic        strap;
        logic        use_m;
        logic [2:0]  n;
        logic [7:0]  b;
        logic [15:0] bitc;
    } vec_t;

    // Expected bit period: 16 * floor(TK / M).
    localparam vec_t VEC [6] = '{
        '{1'b1, 1'b0, 3'd0, 8'hA5, 16'd192},
        '{1'b0, 1'b0, 3'd0, 8'h5B, 16'd96},
        '{1'b0, 1'b1, 3'd3, 8'h81, 16'd64},
        '{1'b1, 1'b1, 3'd5, 8'hFF, 16'd32},
        '{1'b1, 1'b1, 3'd0, 8'h01, 16'd192},
        '{1'b0, 1'b1, 3'd7, 8'h7E, 16'd32}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b1;
    logic       use_m = 1'b0;
    logic [2:0] mult_n = 3'd0;
    logic       host_drv = 1'b1;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       line_oe, line_out, tx_ready, rx_valid, brk, ferr;
    logic [7:0] rx_data;
    wire        line = line_oe ? line_out : host_drv;

    mon_link #(.BASE_BIT_CLKS(BB)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .speed_strap_i (strap),
        .use_mult_i    (use_m),
        .mult_n_i      (mult_n),
        .line_i        (line),
        .line_oe_o     (line_oe),
        .line_out_o    (line_out),
        .tx_valid_i    (tx_valid),
        .tx_data_i     (tx_data),
        .tx_ready_o    (tx_ready),
        .rx_valid_o    (rx_valid),
        .rx_data_o     (rx_data),
        .break_o       (brk),
        .frame_err_o   (ferr)
    );

    always #2 clk = ~clk;

    int         n_chk = 0, n_fail = 0;
    int         rx_cnt = 0, brk_cnt = 0, fe_cnt = 0, drv_cnt = 0;
    int         rdy_in_rx = 0, oe_in_rx = 0;
    logic [7:0] rx_last = 8'h00;
    logic       oe_prev = 1'b0;
    logic       in_frame = 1'b0;
    int         bitc = BB;

    // Event counters sampled at each edge.
    always @(posedge clk) begin
        if (rx_valid) begin
            rx_cnt++;
            rx_last <= rx_data;
        end
        if (brk)  brk_cnt++;
        if (ferr) fe_cnt++;
        if (line_oe && !oe_prev) drv_cnt++;
        oe_prev <= line_oe;
        if (in_frame && tx_ready) rdy_in_rx++;
        if (in_frame && line_oe)  oe_in_rx++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reset_to(input logic s, input logic u, input logic [2:0] n, input int eb);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s;
        use_m = u;
        mult_n = n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        bitc = eb;
        repeat (3 * eb) @(negedge clk);
    endtask

    // Host sends ten bit periods, LSB first; bits[0] is the start bit.
    task automatic host_frame(input logic [9:0] bits);
        for (int i = 0; i < 10; i++) begin
            host_drv = bits[i];
            if (i == 0) begin
                repeat (bitc / 2) @(negedge clk);
                in_frame = 1'b1;
                repeat (bitc - bitc / 2) @(negedge clk);
            end else begin
                repeat (bitc) @(negedge clk);
            end
        end
        host_drv = 1'b1;
        in_frame = 1'b0;
    endtask

    // Wait for the block to drive, then sample each bit at mid-bit and time the drive.
    task automatic capture(output logic [11:0] v, output int dur);
        int w = 0;
        v = '0;
        dur = 0;
        while (!line_oe && w < 60 * bitc) begin
            @(negedge clk);
            w++;
        end
        while (line_oe && dur < 20 * bitc) begin
            if ((dur % bitc) == bitc / 2 && (dur / bitc) < 12) v[dur / bitc] = line;
            dur++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [11:0] v;
        int          dur, r0, d0, b0, f0;
        bit          seen;

        // Table walk: rate selection, reception and echo.
        for (int i = 0; i < 6; i++) begin
            string tag;
            tag = VEC[i].use_m ? "R3 bit period" : "R2 bit period";
            reset_to(VEC[i].strap, VEC[i].use_m, VEC[i].n, int'(VEC[i].bitc));
            r0 = rx_cnt;
            d0 = drv_cnt;
            host_frame({1'b1, VEC[i].b, 1'b0});
            chk("R4 rx_valid count", rx_cnt - r0, 1);
            chk("R4 rx_data", int'(rx_last), int'(VEC[i].b));
            capture(v, dur);
            chk(tag, dur, 10 * int'(VEC[i].bitc));
            chk("R5 echo frame", int'(v), int'({3'b001, VEC[i].b, 1'b0}));
            repeat (4 * bitc) @(negedge clk);
            chk("R5 single echo", drv_cnt - d0, 1);
            chk("R10 own echo not received", rx_cnt - r0, 1);
        end

        // Reset state (R1, R11).
        @(negedge clk);
        rst_n = 1'b0;
        strap = 1'b0;
        use_m = 1'b0;
        mult_n = 3'd0;
        repeat (4) @(negedge clk);
        chk("R1 released in reset", int'(line_oe), 0);
        chk("R11 not ready in reset", int'(tx_ready), 0);
        chk("R4 no rx pulse in reset", int'(rx_valid), 0);
        rst_n = 1'b1;
        bitc = 96;
        repeat (3 * bitc) @(negedge clk);

        // R2: a strap change after reset has no effect.
        strap = 1'b1;
        d0 = drv_cnt;
        host_frame({1'b1, 8'h01, 1'b0});
        capture(v, dur);
        chk("R2 strap ignored after reset", dur, 10 * 96);
        chk("R5 echo frame", int'(v), int'({3'b001, 8'h01, 1'b0}));
        repeat (3 * bitc) @(negedge clk);

        // Break, then the break answer (R6, R7).
        r0 = rx_cnt;
        b0 = brk_cnt;
        host_frame(10'b0);
        chk("R6 break pulse", brk_cnt - b0, 1);
        chk("R6 no byte on break", rx_cnt - r0, 0);
        capture(v, dur);
        chk("R7 answer pattern", int'(v), int'(12'b0000_0000_0011));
        chk("R7 answer length", dur, 12 * bitc);
        repeat (3 * bitc) @(negedge clk);

        // Framing error (R8).
        r0 = rx_cnt;
        f0 = fe_cnt;
        d0 = drv_cnt;
        host_frame({1'b0, 8'h12, 1'b0});
        repeat (30 * bitc) @(negedge clk);
        chk("R8 frame_err pulse", fe_cnt - f0, 1);
        chk("R8 no byte", rx_cnt - r0, 0);
        chk("R8 no echo", drv_cnt - d0, 0);

        // Start glitch (R9).
        r0 = rx_cnt;
        f0 = fe_cnt;
        b0 = brk_cnt;
        d0 = drv_cnt;
        host_drv = 1'b0;
        repeat (2 * (bitc / 16)) @(negedge clk);
        host_drv = 1'b1;
        repeat (30 * bitc) @(negedge clk);
        chk("R9 glitch no byte", rx_cnt - r0, 0);
        chk("R9 glitch no error", (fe_cnt - f0) + (brk_cnt - b0), 0);
        chk("R9 glitch no drive", drv_cnt - d0, 0);

        // Local byte through the handshake (R11, R1).
        d0 = drv_cnt;
        r0 = rx_cnt;
        tx_data = 8'h3C;
        tx_valid = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 40 * bitc && !seen; k++) begin
            @(posedge clk);
            if (tx_ready) seen = 1'b1;
        end
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R11 ready seen", int'(seen), 1);
        capture(v, dur);
        chk("R1 local frame", int'(v), int'({3'b001, 8'h3C, 1'b0}));
        chk("R1 local frame length", dur, 10 * bitc);
        repeat (20 * bitc) @(negedge clk);
        chk("R11 sent once", drv_cnt - d0, 1);
        chk("R10 local frame not received", rx_cnt - r0, 0);

        // Hold-off over every host frame (R10).
        chk("R10 ready during host frame", rdy_in_rx, 0);
        chk("R10 drive during host frame", oe_in_rx, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule